// File: doc/BRIEF.md
# Approximate Compressor-Tree Multiplier

This block multiplies two unsigned N-bit operands (N = 8 by default) and returns a 2N-bit product. The partial-product rows are AND terms. A tree of 4:2 compressor rows brings them down to two rows in log2(N)-1 stages: 8 rows, then 4, then 2 for the default width. An exact adder then sums the last two rows.

Each compressor cell is one of three kinds: exact, approximate variant 1 (with carry-in and carry-out), or approximate variant 2 (no carry-in or carry-out). A synthesis-time parameter picks the kind used in the low columns. All remaining columns use exact cells. This allows all-exact, all-approximate and mixed builds, where the mixed build puts approximate cells only in the N-1 least significant columns. A second parameter chooses whether the product is registered or combinational. The block is meant for error-tolerant signal-processing datapaths, where the smaller and shallower approximate cells are worth the loss of accuracy.

Top module: `cmptree_mul`

## Requirements
- R1: When KIND is exact, or APX_COLS is 0, prod equals op_a*op_b for every one of the 2^(2N) operand pairs.
- R2: In every configuration, prod is 0 whenever op_a or op_b is 0.
- R3: With OUT_REG=1, prod shows the result for the operands that were present at the previous rising clock edge. The asynchronous active-low rst_n clears prod to 0. With OUT_REG=0, prod follows the operands combinationally.
- R4: An exact cell satisfies x1+x2+x3+x4+cin = sum + 2*(carry+cout). Its cout is the majority of x1, x2 and x3, so cout does not depend on cin.
- R5: A variant-1 cell computes carry = cin, cout = x1&x2 | x3&x4, and sum = cin & ((x1^x2) | (x3^x4)).
- R6: A variant-2 cell computes sum = (x1^x2) | (x3^x4) and carry = x1&x2 | x3&x4, and its cout is 0. A tree built only from variant-2 cells and exact cells never returns a product larger than op_a*op_b.
- R7: Columns 0 to APX_COLS-1 use the cell kind given by KIND, and all higher columns use exact cells. KIND is encoded as exact = 0, variant 1 = 1, variant 2 = 2. The default build is variant 1 with APX_COLS = N-1.
- R8: Partial-product row j is op_a shifted left by j and masked by op_b[j]. Each stage takes its rows in groups of four. A group becomes one sum row plus one carry row, and the carry row is shifted up by one column. In each compressor row, the cout of column i feeds the cin of column i+1, and column 0 has cin = 0. Outputs of the top column are discarded.
- R9: The two rows left after the last stage are added by an exact 2N-bit adder, modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| prod | output | 2N | Product, exact or approximate depending on configuration |

## Verification
The assertions assume that op_a and op_b are known and steady at every rising clock edge after reset. They compare prod against operands that were captured one edge earlier when the output is registered. The bench therefore changes operands only on falling edges and holds them for a full cycle. It also keeps reset asserted for several edges so that the captured operands are valid before any property is armed. The exact-product and no-overestimate properties are enabled only for configurations whose parameters guarantee them, and the bench instantiates those configurations side by side with approximate ones.

// File: rtl/cmptree_pkg.sv
package cmptree_pkg;
   // Compressor cell kind; encoding is part of the parameter contract.
   typedef enum logic [1:0] {
      CK_EXACT = 2'd0,
      CK_APX1  = 2'd1,
      CK_APX2  = 2'd2
   } cmp_kind_e;
endpackage

// File: rtl/cmp42_cell.sv
module cmp42_cell
   import cmptree_pkg::*;
#(
   parameter cmp_kind_e KIND = CK_EXACT
) (
   input  logic [3:0] x,
   input  logic       cin,
   output logic       sum,
   output logic       carry,
   output logic       cout
);

   generate
      if (KIND == CK_EXACT) begin : g_exact
         // R4: two chained full adders, cout independent of cin
         logic s1;
         assign s1    = x[0] ^ x[1] ^ x[2];
         assign cout  = (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
         assign sum   = s1 ^ x[3] ^ cin;
         assign carry = (s1 & x[3]) | (s1 & cin) | (x[3] & cin);
      end else if (KIND == CK_APX1) begin : g_apx1
         // R5
         assign carry = cin;
         assign cout  = (x[0] & x[1]) | (x[2] & x[3]);
         assign sum   = cin & ((x[0] ^ x[1]) | (x[2] ^ x[3]));
      end else begin : g_apx2
         // R6
         logic unused_cin;
         assign unused_cin = cin;
         assign sum   = (x[0] ^ x[1]) | (x[2] ^ x[3]);
         assign carry = (x[0] & x[1]) | (x[2] & x[3]);
         assign cout  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cmp_row.sv
module cmp_row
   import cmptree_pkg::*;
#(
   parameter int        W        = 16,
   parameter cmp_kind_e KIND     = CK_APX1,
   parameter int        APX_COLS = 7
) (
   input  logic [W-1:0] x0,
   input  logic [W-1:0] x1,
   input  logic [W-1:0] x2,
   input  logic [W-1:0] x3,
   output logic [W-1:0] s_row,
   output logic [W-1:0] c_row
);

   logic [W:0]   chain;
   logic [W-1:0] cy;
   logic         unused_top;

   assign chain[0] = 1'b0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_col
         if (i < APX_COLS) begin : g_apx
            cmp42_cell #(.KIND(KIND)) u_cell (
               .x    ({x3[i], x2[i], x1[i], x0[i]}),
               .cin  (chain[i]),
               .sum  (s_row[i]),
               .carry(cy[i]),
               .cout (chain[i+1])
            );
         end else begin : g_ex
            cmp42_cell #(.KIND(CK_EXACT)) u_cell (
               .x    ({x3[i], x2[i], x1[i], x0[i]}),
               .cin  (chain[i]),
               .sum  (s_row[i]),
               .carry(cy[i]),
               .cout (chain[i+1])
            );
         end
      end
   endgenerate

   // R8: carry row moves up one column; top-column outputs are discarded
   assign c_row      = {cy[W-2:0], 1'b0};
   assign unused_top = chain[W] ^ cy[W-1];

endmodule

// File: rtl/cmptree_mul.sv
module cmptree_mul
   import cmptree_pkg::*;
#(
   parameter int        N        = 8,
   parameter cmp_kind_e KIND     = CK_APX1,
   parameter int        APX_COLS = N - 1,
   parameter bit        OUT_REG  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   op_a,
   input  logic [N-1:0]   op_b,
   output logic [2*N-1:0] prod
);

   localparam int W      = 2 * N;
   localparam int STAGES = $clog2(N) - 1;

   generate
      if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("cmptree_mul: N must be a power of two, at least 4");
      end
      if (APX_COLS < 0 || APX_COLS > W) begin : g_bad_cols
         $error("cmptree_mul: APX_COLS must lie in 0..2N");
      end
   endgenerate

   // R8: AND-array partial products
   logic [W-1:0] pp [N];
   generate
      for (genvar j = 0; j < N; j++) begin : g_pp
         assign pp[j] = (W'(op_a) & {W{op_b[j]}}) << j;
      end
   endgenerate

   // R8: stages of 4:2 rows, each halving the row count
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         localparam int RIN = N >> s;
         logic [W-1:0] rin  [RIN];
         logic [W-1:0] rout [RIN/2];
         if (s == 0) begin : g_src
            assign rin = pp;
         end else begin : g_src
            assign rin = g_st[s-1].rout;
         end
         for (genvar g = 0; g < RIN / 4; g++) begin : g_grp
            cmp_row #(.W(W), .KIND(KIND), .APX_COLS(APX_COLS)) u_row (
               .x0   (rin[4*g]),
               .x1   (rin[4*g+1]),
               .x2   (rin[4*g+2]),
               .x3   (rin[4*g+3]),
               .s_row(rout[2*g]),
               .c_row(rout[2*g+1])
            );
         end
      end
   endgenerate

   // R9: exact carry-propagate adder
   logic [W-1:0] sum_w;
   assign sum_w = g_st[STAGES-1].rout[0] + g_st[STAGES-1].rout[1];

   // R3: optional output register
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod <= '0;
            else        prod <= sum_w;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign prod       = sum_w;
      end
   endgenerate

endmodule

// File: rtl/cmptree_mul_chk.sv
module cmptree_mul_chk
   import cmptree_pkg::*;
#(
   parameter int        N        = 8,
   parameter cmp_kind_e KIND     = CK_APX1,
   parameter int        APX_COLS = N - 1,
   parameter bit        OUT_REG  = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   op_a,
   input logic [N-1:0]   op_b,
   input logic [2*N-1:0] prod
);

   localparam int W         = 2 * N;
   localparam bit EXACT_CFG = (KIND == CK_EXACT) || (APX_COLS == 0);
   localparam bit NO_OVER   = (KIND != CK_APX1) || (APX_COLS == 0);

   logic         armed;
   logic [N-1:0] ca, cb;
   logic [W-1:0] exact_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   generate
      if (OUT_REG) begin : g_cap
         logic [N-1:0] a_q, b_q;
         always_ff @(posedge clk) begin
            a_q <= op_a;
            b_q <= op_b;
         end
         assign ca = a_q;
         assign cb = b_q;
      end else begin : g_cap
         assign ca = op_a;
         assign cb = op_b;
      end
   endgenerate

   assign exact_p = W'(ca) * W'(cb);

   generate
      if (EXACT_CFG) begin : g_exact
         a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> prod == exact_p);
      end
      if (NO_OVER) begin : g_bound
         a_r6_no_overestimate: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> prod <= exact_p);
      end
      if (OUT_REG) begin : g_hold
         a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $stable(op_a) && $stable(op_b) |=> $stable(prod));
      end else begin : g_hold
         a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $stable(op_a) && $stable(op_b) |-> $stable(prod));
      end
   endgenerate

   a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (ca == '0 || cb == '0) |-> prod == '0);

endmodule

bind cmptree_mul cmptree_mul_chk #(
   .N(N), .KIND(KIND), .APX_COLS(APX_COLS), .OUT_REG(OUT_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/test_cmptree_mul.sv
`timescale 1ns/1ps
module test_cmptree_mul;
   import cmptree_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_a = '0;
   logic [7:0]  op_b = '0;
   logic [15:0] p_mix, p_ex, p_a1, p_a2;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit collect = 1'b0;
   int bad_mix = 0, bad_a1 = 0, bad_a2 = 0;
   longint ed_mix = 0, ed_a1 = 0, ed_a2 = 0;

   always #5 clk = ~clk;

   // default build: variant 1 in the low N-1 columns, registered
   cmptree_mul i_cmptree_mul (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_mix));
   cmptree_mul #(.KIND(CK_EXACT), .OUT_REG(1'b1)) i_cmptree_mul_ex (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_ex));
   cmptree_mul #(.KIND(CK_APX1), .APX_COLS(16), .OUT_REG(1'b0)) i_cmptree_mul_a1 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_a1));
   cmptree_mul #(.KIND(CK_APX2), .APX_COLS(16), .OUT_REG(1'b0)) i_cmptree_mul_a2 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_a2));

   // one compressor row per the requirement equations (R4 R5 R6 R8)
   function automatic void row_m(input logic [15:0] x0, x1, x2, x3,
                                 input int kind, input int apx,
                                 output logic [15:0] s, output logic [15:0] c);
      logic cin, co, cy, sm, t, a0, a1, a2, a3;
      cin = 1'b0;
      s = '0;
      c = '0;
      for (int i = 0; i < 16; i++) begin
         a0 = x0[i]; a1 = x1[i]; a2 = x2[i]; a3 = x3[i];
         case ((i < apx) ? kind : 0)
            1: begin
               cy = cin;
               co = (a0 & a1) | (a2 & a3);
               sm = cin & ((a0 ^ a1) | (a2 ^ a3));
            end
            2: begin
               sm = (a0 ^ a1) | (a2 ^ a3);
               cy = (a0 & a1) | (a2 & a3);
               co = 1'b0;
            end
            default: begin
               t  = a0 ^ a1 ^ a2;
               co = (a0 & a1) | (a0 & a2) | (a1 & a2);
               sm = t ^ a3 ^ cin;
               cy = (t & a3) | (t & cin) | (a3 & cin);
            end
         endcase
         s[i] = sm;
         if (i < 15) c[i+1] = cy;
         cin = co;
      end
   endfunction

   function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input int kind, input int apx);
      logic [15:0] r [8];
      logic [15:0] s, c;
      int n;
      for (int j = 0; j < 8; j++) r[j] = ({8'b0, a} & {16{b[j]}}) << j;
      n = 8;
      while (n > 2) begin
         for (int g = 0; g < n / 4; g++) begin
            row_m(r[4*g], r[4*g+1], r[4*g+2], r[4*g+3], kind, apx, s, c);
            r[2*g]   = s;
            r[2*g+1] = c;
         end
         n = n / 2;
      end
      return r[0] + r[1];  // R9
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, op_a, op_b, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // all four instances compared for the operands driven one cycle earlier
   task automatic check_all(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] ex, m_mix, m_a1, m_a2;
      ex    = {8'b0, a} * {8'b0, b};
      m_mix = model(a, b, 1, 7);
      m_a1  = model(a, b, 1, 16);
      m_a2  = model(a, b, 2, 16);
      chk("R1 R4 exact", p_ex, ex);
      chk("R7 R8 R9 mixed", p_mix, m_mix);
      chk("R5 variant1", p_a1, m_a1);
      chk("R6 variant2", p_a2, m_a2);
      checks++;
      if (p_a2 > ex) begin
         errors++;
         $display("FAIL R6 bound a=%0d b=%0d actual=%0d expected<=%0d", a, b, p_a2, ex);
      end
      if (a == 0 || b == 0) begin
         chk("R2 zero mixed", p_mix, 16'd0);
         chk("R2 zero exact", p_ex, 16'd0);
         chk("R2 zero v1", p_a1, 16'd0);
         chk("R2 zero v2", p_a2, 16'd0);
      end
      if (collect) begin
         if (p_mix != ex) bad_mix++;
         if (p_a1 != ex) bad_a1++;
         if (p_a2 != ex) bad_a2++;
         ed_mix += (p_mix > ex) ? p_mix - ex : ex - p_mix;
         ed_a1  += (p_a1 > ex) ? p_a1 - ex : ex - p_a1;
         ed_a2  += (p_a2 > ex) ? p_a2 - ex : ex - p_a2;
      end
   endtask

   task automatic apply(input logic [7:0] a, input logic [7:0] b);
      op_a = a;
      op_b = b;
      @(negedge clk);
      check_all(a, b);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240917));
      // R3: reset holds registered outputs at zero
      repeat (2) @(negedge clk);
      op_a = 8'd5;
      op_b = 8'd7;
      repeat (2) @(negedge clk);
      chk("R3 reset exact", p_ex, 16'd0);
      chk("R3 reset mixed", p_mix, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 first capture", p_ex, 16'd35);
      // R3: registered output lags, combinational follows at once
      op_a = 8'd3;
      op_b = 8'd9;
      #2;
      chk("R3 still old", p_ex, 16'd35);
      chk("R3 comb follows", p_a2, model(8'd3, 8'd9, 2, 16));
      @(negedge clk);
      chk("R3 one cycle later", p_ex, 16'd27);

      // directed corners
      apply(8'd255, 8'd255);
      apply(8'd0, 8'd255);
      apply(8'd255, 8'd0);
      apply(8'd1, 8'd173);
      apply(8'd128, 8'd128);
      apply(8'd85, 8'd170);
      apply(8'd1, 8'd1);

      // constrained random: bias half of the draws toward dense operands
      for (int k = 0; k < 2000; k++) begin
         logic [7:0] a, b;
         a = 8'($urandom);
         b = 8'($urandom);
         if (k[0]) begin
            a = a | 8'($urandom);
            b = b | 8'($urandom);
         end
         apply(a, b);
      end

      // exhaustive sweep with error statistics
      collect = 1'b1;
      for (int v = 0; v < 65536; v++) apply(v[15:8], v[7:0]);
      collect = 1'b0;
      $display("mixed v1 : error rate %0d/65536, mean error distance %f",
               bad_mix, real'(ed_mix) / 65536.0);
      $display("all v1   : error rate %0d/65536, mean error distance %f",
               bad_a1, real'(ed_a1) / 65536.0);
      $display("all v2   : error rate %0d/65536, mean error distance %f",
               bad_a2, real'(ed_a2) / 65536.0);
      finish_run();
   end

endmodule